// File: doc/BRIEF.md
# Peripheral Region Address Decoder

This block sits between a processor's bus and its peripheral fabric. It looks at every 32-bit bus address and works out whether the address lands in one of two 2 MB peripheral windows: a fast window covering the top 2 MB of the address space, and a slow window starting at 0xE0000000. Each window is carved into 128 equal 16 KB slots. A valid data access to a slot that holds a peripheral raises exactly one select line and hands the peripheral a word offset. The offset keeps only as many low bits as that peripheral needs to tell its registers apart.

Two kinds of access are rejected. An instruction fetch anywhere inside either window is refused with a fetch abort, because code is never run from register space. A data access to an empty slot is refused with a data abort. Addresses outside both windows produce no select and no abort, so the memory decoder can claim them.

Which slots are populated, and how many offset bits each slot decodes, are fixed at elaboration through parameters for each window. The decode is purely combinational, so its outputs follow the inputs in the same cycle.

Top module: `periph_addr_decode`

## Requirements
- R1: A valid data access with address[31:21] equal to 0x700 (0xE0000000 to 0xE01FFFFF) to a populated slot drives the bit of `ls_sel_o` indexed by address[20:14] high, and drives every other select bit low.
- R2: A valid data access with address[31:21] equal to 0x7FF (0xFFE00000 to 0xFFFFFFFF) to a populated slot drives the bit of `hs_sel_o` indexed by address[20:14] high, and drives every other select bit low.
- R3: Across `ls_sel_o` and `hs_sel_o` together, at most one bit is high at any time.
- R4: A valid access with `is_fetch_i` = 1 (1 = instruction fetch, 0 = data) into either window raises `fetch_abort_o`. It raises no select and no `data_abort_o`, whether the slot is populated or not.
- R5: A valid data access to an unpopulated slot of either window raises `data_abort_o` and no select.
- R6: For a selected slot decoding W offset bits, `word_off_o` equals address[13:2] with every bit at position W or above forced to zero. Offsets past the defined registers alias onto them and raise no abort.
- R7: Address bits [1:0] have no effect on any output.
- R8: A valid access outside both windows drives all selects, both aborts, `slot_idx_o` and `word_off_o` to zero.
- R9: With `valid_i` low, all selects, both aborts, `slot_idx_o` and `word_off_o` are zero.
- R10: For a valid access inside either window, `slot_idx_o` equals address[20:14], including when the access aborts. `word_off_o` is zero whenever no select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| valid_i | input | 1 | Access strobe qualifying the address |
| is_fetch_i | input | 1 | 1 = instruction fetch, 0 = data access |
| addr_i | input | 32 | Byte address of the access |
| ls_sel_o | output | 128 | One-hot slot select for the slow window |
| hs_sel_o | output | 128 | One-hot slot select for the fast window |
| slot_idx_o | output | 7 | Slot number within the hit window |
| word_off_o | output | 12 | Word offset, truncated to the slot's decode width |
| fetch_abort_o | output | 1 | Instruction fetch into peripheral space |
| data_abort_o | output | 1 | Data access to an empty slot |

## Verification
The bench goes after the window edges: 0xDFFFFFFC, 0xE0200000 and 0xFFDFFFFC. A region compare off by one bit would select a slot or abort on those addresses. It checks fetches into populated slots, where a design that only aborts on empty slots would wrongly raise a select. It checks fetches into empty slots, where raising the data abort as well would be wrong. It drives offsets well beyond each slot's register count, where a design that aborts on them, or fails to mask the high bits, would break the intended aliasing. Byte-address bits and idle cycles are swept to catch decode that leaks from the low two bits or from an unqualified strobe.

// File: rtl/pdec_pkg.sv
package pdec_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned SLOT_W  = 7;
  localparam int unsigned SLOTS   = 1 << SLOT_W;
  localparam int unsigned SLOT_LO = 14;              // 16 KB slots
  localparam int unsigned TAG_LO  = SLOT_LO + SLOT_W; // 2 MB windows
  localparam int unsigned TAG_W   = ADDR_W - TAG_LO;
  localparam int unsigned OFF_W   = SLOT_LO - 2;     // word offset bits
  localparam int unsigned WID_W   = 4;

  typedef logic [SLOTS*WID_W-1:0] width_tbl_t;

  // spread decode widths over 0..OFF_W so defaults exercise many sizes
  function automatic width_tbl_t spread_widths(int unsigned seed);
    width_tbl_t t;
    t = '0;
    for (int unsigned i = 0; i < SLOTS; i++)
      t[i*WID_W +: WID_W] = WID_W'((i * 5 + seed) % (OFF_W + 1));
    return t;
  endfunction

  localparam logic [TAG_W-1:0] LS_TAG_DEF = 11'h700;
  localparam logic [TAG_W-1:0] HS_TAG_DEF = 11'h7FF;
  localparam logic [SLOTS-1:0] LS_POP_DEF = 128'h8000_0000_0000_0000_0000_0000_0000_0CAF;
  localparam logic [SLOTS-1:0] HS_POP_DEF = 128'h8000_0000_0000_0000_0000_0000_0000_0001;
  localparam width_tbl_t       LS_WID_DEF = spread_widths(1);
  localparam width_tbl_t       HS_WID_DEF = spread_widths(7);
endpackage

// File: rtl/pdec_region.sv
module pdec_region
  import pdec_pkg::*;
#(
  parameter logic [TAG_W-1:0] TAG    = LS_TAG_DEF,
  parameter logic [SLOTS-1:0] POP    = LS_POP_DEF,
  parameter width_tbl_t       WIDTHS = LS_WID_DEF
) (
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic              hit_o,
  output logic              pop_o,
  output logic [WID_W-1:0]  width_o
);
  assign hit_o   = (tag_i == TAG);
  assign pop_o   = hit_o & POP[slot_i];
  assign width_o = hit_o ? WIDTHS[slot_i*WID_W +: WID_W] : '0;
endmodule

// File: rtl/pdec_offset_mask.sv
module pdec_offset_mask
  import pdec_pkg::*;
(
  input  logic [OFF_W-1:0] off_i,
  input  logic [WID_W-1:0] width_i,
  output logic [OFF_W-1:0] off_o
);
  // keep only the bits the peripheral decodes; the rest alias
  for (genvar b = 0; b < OFF_W; b++) begin : g_bit
    assign off_o[b] = off_i[b] & (width_i > WID_W'(b));
  end
endmodule

// File: rtl/pdec_onehot.sv
module pdec_onehot
  import pdec_pkg::*;
(
  input  logic              en_i,
  input  logic [SLOT_W-1:0] idx_i,
  output logic [SLOTS-1:0]  vec_o
);
  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    assign vec_o[k] = en_i & (idx_i == SLOT_W'(k));
  end
endmodule

// File: rtl/periph_addr_decode.sv
module periph_addr_decode
  import pdec_pkg::*;
#(
  parameter logic [TAG_W-1:0] LS_TAG    = LS_TAG_DEF,
  parameter logic [TAG_W-1:0] HS_TAG    = HS_TAG_DEF,
  parameter logic [SLOTS-1:0] LS_POP    = LS_POP_DEF,
  parameter logic [SLOTS-1:0] HS_POP    = HS_POP_DEF,
  parameter width_tbl_t       LS_WIDTHS = LS_WID_DEF,
  parameter width_tbl_t       HS_WIDTHS = HS_WID_DEF
) (
  input  logic              valid_i,
  input  logic              is_fetch_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [SLOTS-1:0]  ls_sel_o,
  output logic [SLOTS-1:0]  hs_sel_o,
  output logic [SLOT_W-1:0] slot_idx_o,
  output logic [OFF_W-1:0]  word_off_o,
  output logic              fetch_abort_o,
  output logic              data_abort_o
);
  logic [TAG_W-1:0]  tag;
  logic [SLOT_W-1:0] slot;
  logic [OFF_W-1:0]  raw_off, masked_off;
  logic [1:0]        byte_lane_unused;
  logic              ls_hit, hs_hit, ls_pop, hs_pop;
  logic [WID_W-1:0]  ls_wid, hs_wid, sel_wid;
  logic              any_hit, data_ok, ls_en, hs_en;

  assign tag              = addr_i[ADDR_W-1:TAG_LO];
  assign slot             = addr_i[TAG_LO-1:SLOT_LO];
  assign raw_off          = addr_i[SLOT_LO-1:2];
  assign byte_lane_unused = addr_i[1:0]; // registers are word aligned

  pdec_region #(.TAG(LS_TAG), .POP(LS_POP), .WIDTHS(LS_WIDTHS)) u_ls (
    .tag_i(tag), .slot_i(slot), .hit_o(ls_hit), .pop_o(ls_pop), .width_o(ls_wid)
  );
  pdec_region #(.TAG(HS_TAG), .POP(HS_POP), .WIDTHS(HS_WIDTHS)) u_hs (
    .tag_i(tag), .slot_i(slot), .hit_o(hs_hit), .pop_o(hs_pop), .width_o(hs_wid)
  );

  assign any_hit = valid_i & (ls_hit | hs_hit);
  assign data_ok = valid_i & ~is_fetch_i;
  assign ls_en   = data_ok & ls_pop;
  assign hs_en   = data_ok & hs_pop;

  pdec_onehot u_ls_sel (.en_i(ls_en), .idx_i(slot), .vec_o(ls_sel_o));
  pdec_onehot u_hs_sel (.en_i(hs_en), .idx_i(slot), .vec_o(hs_sel_o));

  assign sel_wid = ls_en ? ls_wid : (hs_en ? hs_wid : '0);

  pdec_offset_mask u_off (.off_i(raw_off), .width_i(sel_wid), .off_o(masked_off));

  assign word_off_o    = (ls_en | hs_en) ? masked_off : '0;
  assign slot_idx_o    = any_hit ? slot : '0;
  assign fetch_abort_o = any_hit & is_fetch_i;
  assign data_abort_o  = any_hit & ~is_fetch_i & ~(ls_pop | hs_pop);
endmodule

// File: rtl/periph_addr_decode_chk.sv
module periph_addr_decode_chk
  import pdec_pkg::*;
(
  input logic              valid_i,
  input logic              is_fetch_i,
  input logic [SLOTS-1:0]  ls_sel_o,
  input logic [SLOTS-1:0]  hs_sel_o,
  input logic [OFF_W-1:0]  word_off_o,
  input logic              fetch_abort_o,
  input logic              data_abort_o
);
  logic [2*SLOTS-1:0] all_sel;
  assign all_sel = {ls_sel_o, hs_sel_o};

  always_comb begin
    a_r3_single_select: assert ($onehot0(all_sel));
    a_r9_idle_quiet: assert (valid_i || (!fetch_abort_o && !data_abort_o && all_sel == '0));
    a_r4_fetch_never_selects: assert (!(valid_i && is_fetch_i) || all_sel == '0);
    a_r4_abort_kinds_exclusive: assert (!(fetch_abort_o && data_abort_o));
    a_r5_abort_without_select: assert (!data_abort_o || all_sel == '0);
    a_r10_offset_needs_select: assert (word_off_o == '0 || all_sel != '0);
  end
endmodule

bind periph_addr_decode periph_addr_decode_chk chk_i (
  .valid_i(valid_i), .is_fetch_i(is_fetch_i), .ls_sel_o(ls_sel_o), .hs_sel_o(hs_sel_o),
  .word_off_o(word_off_o), .fetch_abort_o(fetch_abort_o), .data_abort_o(data_abort_o)
);

// File: tb/periph_addr_decode_tb_top.sv
module periph_addr_decode_tb_top;
  import pdec_pkg::*;

  logic clk = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  logic              valid_i = 1'b0;
  logic              is_fetch_i = 1'b0;
  logic [31:0]       addr_i = '0;
  logic [SLOTS-1:0]  ls_sel_o, hs_sel_o;
  logic [SLOT_W-1:0] slot_idx_o;
  logic [OFF_W-1:0]  word_off_o;
  logic              fetch_abort_o, data_abort_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  periph_addr_decode dut_i (.*);

  // behavioural reference: integer arithmetic on the address
  task automatic check(input string req);
    longint unsigned a;
    int region, slot, w, off;
    bit pop;
    logic [SLOTS-1:0] e_ls, e_hs;
    int e_slot, e_off;
    bit e_fa, e_da;
    a = longint'(addr_i);
    region = 0;
    if (a >= 64'hE000_0000 && a < 64'hE020_0000) region = 1;
    else if (a >= 64'hFFE0_0000) region = 2;
    slot = int'((a % (2*1024*1024)) / (16*1024));
    off  = int'((a % (16*1024)) / 4);
    pop = 1'b0; w = 0;
    if (region == 1) begin pop = LS_POP_DEF[slot]; w = int'(LS_WID_DEF[slot*4 +: 4]); end
    if (region == 2) begin pop = HS_POP_DEF[slot]; w = int'(HS_WID_DEF[slot*4 +: 4]); end
    e_ls = '0; e_hs = '0; e_slot = 0; e_off = 0; e_fa = 0; e_da = 0;
    if (valid_i && region != 0) begin
      e_slot = slot;
      if (is_fetch_i) e_fa = 1;
      else if (!pop) e_da = 1;
      else begin
        if (region == 1) e_ls[slot] = 1'b1; else e_hs[slot] = 1'b1;
        e_off = off % (1 << w);
      end
    end
    n_cmp++;
    if (ls_sel_o !== e_ls || hs_sel_o !== e_hs || int'(slot_idx_o) != e_slot ||
        int'(word_off_o) != e_off || fetch_abort_o !== e_fa || data_abort_o !== e_da) begin
      n_bad++;
      $display("FAIL %s addr=%h v=%0b f=%0b: act ls=%h hs=%h slot=%0d off=%0d fa=%0b da=%0b exp ls=%h hs=%h slot=%0d off=%0d fa=%0b da=%0b",
               req, addr_i, valid_i, is_fetch_i, ls_sel_o, hs_sel_o, slot_idx_o, word_off_o,
               fetch_abort_o, data_abort_o, e_ls, e_hs, e_slot, e_off, e_fa, e_da);
    end
  endtask

  task automatic apply(input bit v, input bit f, input logic [31:0] a, input string req);
    @(negedge clk);
    valid_i = v; is_fetch_i = f; addr_i = a;
    #1 check(req);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    #1 check("R9"); // idle state at start
    apply(0, 0, 32'hE000_0000, "R9");
    apply(1, 0, 32'hE000_0000, "R1");
    apply(1, 0, 32'hE001_4008, "R1");
    apply(1, 0, 32'hE01F_C000, "R1");
    apply(1, 0, 32'hE002_8010, "R1");
    apply(1, 0, 32'hFFFF_F000, "R2");
    apply(1, 0, 32'hFFE0_0004, "R2");
    apply(1, 0, 32'hE001_0000, "R5");
    apply(1, 0, 32'hFFE0_4000, "R5");
    apply(1, 0, 32'hE000_C100, "R10");
    apply(1, 1, 32'hE000_0000, "R4");
    apply(1, 1, 32'hFFFF_F000, "R4");
    apply(1, 1, 32'hE001_0000, "R4");
    apply(1, 0, 32'hE000_0008, "R6");
    apply(1, 0, 32'hE000_3FFC, "R6");
    apply(1, 0, 32'hE01F_FFFC, "R6");
    apply(1, 0, 32'hFFFF_FFFC, "R6");
    apply(1, 0, 32'hE000_4004, "R7");
    apply(1, 0, 32'hE000_4007, "R7");
    apply(1, 0, 32'hE000_4005, "R7");
    apply(1, 0, 32'h0000_0000, "R8");
    apply(1, 0, 32'hDFFF_FFFC, "R8");
    apply(1, 0, 32'hE020_0000, "R8");
    apply(1, 0, 32'hFFDF_FFFC, "R8");
    apply(1, 1, 32'h4000_0000, "R8");
    apply(0, 1, 32'hFFFF_F000, "R9");
    apply(0, 0, 32'hE001_0000, "R9");
    // biased pseudo-random sweep
    lfsr = 32'h1D2C_3B4A;
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a;
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      a = lfsr;
      case (lfsr[31:30])
        2'd0: a[31:21] = LS_TAG_DEF;
        2'd1: a[31:21] = HS_TAG_DEF;
        2'd2: begin a[31:21] = LS_TAG_DEF; a[20:14] = {3'b000, lfsr[13:10]}; end
        default: ;
      endcase
      apply(lfsr[9] | lfsr[8], lfsr[7] & lfsr[6], a, "R3");
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule